// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Clock Generator

This block produces the serial timing for a stereo audio port that acts as clock master. From a single master clock it derives a bit clock and two frame (left/right) clocks, one for the converter input path and one for the output path. Both frame clocks are driven from one shared position counter, so they are always identical and phase-aligned.

Two clocking schemes are supported. In divided mode the bit clock is the master clock divided by an even ratio chosen by `rate_sel`, and each frame holds 64 bit clocks, with the frame clock high for exactly half of them. In pass-through mode, meant for a fixed 12 MHz system clock, the bit clock runs at the master clock rate. The frame then lasts a whole number of master clocks picked by `rate_sel`, and that count may be odd, which gives an asymmetric frame clock (for 375 clocks: 187 high, 188 low).

Frame-clock edges always coincide with a falling edge of the bit clock as the receiver interprets it. An invert control flips the bit-clock pin. A standby input parks every output low. On wake-up the block restarts at the beginning of a left (high) phase, so the first frame is complete. The configuration inputs are captured only while the block is idle.

Top module: `audio_clkgen`

## Requirements
- R1: In divided mode the bit-clock period is 2*H master clocks, where H is 2, 3, 4 or 6 for `rate_sel` 0, 1, 2 or 3.
- R2: In divided mode each frame-clock phase lasts 32 bit-clock periods (64*H master clocks), high and low alike.
- R3: In pass-through mode, with invert off, `bclk` is low while the master clock is high and high while it is low, so its falling edges coincide with the master clock's rising edges.
- R4: In pass-through mode a frame lasts F master clocks, where F is 250, 272, 375 or 1500 for `rate_sel` 0 to 3. The high phase lasts floor(F/2) and the low phase lasts the rest (375 gives 187 high and 188 low).
- R5: While running, every frame-clock edge falls at a falling edge of the effective bit clock (`bclk` XOR `bclk_inv`).
- R6: While running, `bclk_inv`=1 inverts the `bclk` pin. The pin reads 1 in the first running cycle instead of 0.
- R7: `adc_lrc` and `dac_lrc` are equal at every instant.
- R8: During reset, and from the first clock edge after `standby` is sampled high, `bclk`, `adc_lrc` and `dac_lrc` are all low.
- R9: After `standby` is released at edge E1, the first frame-clock edge is a rise (left phase). It occurs at edge E(1+2H) in divided mode and at E3 in pass-through mode, and the first high phase has full length.
- R10: `usb_mode`, `rate_sel` and `bclk_inv` are captured only while the block is idle. Changing them while running alters neither the bit-clock nor the frame-clock timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_mode | input | 1 | 1 selects pass-through clocking, 0 selects divided clocking |
| rate_sel | input | 2 | Selects the division ratio or the frame length |
| bclk_inv | input | 1 | Inverts the bit-clock pin |
| standby | input | 1 | Parks all outputs low; releasing it restarts a frame |
| bclk | output | 1 | Bit clock |
| adc_lrc | output | 1 | Frame clock for the converter input path (high = left) |
| dac_lrc | output | 1 | Frame clock for the converter output path (high = left) |

## Verification
A frame-clock transition and a bit-clock falling edge are meant to land in the same master-clock cycle. The bench samples the bit clock twice per master clock, once in each half, so that it sees the falling edge in pass-through mode as well as in divided mode. Every frame-clock change is judged against the effective bit-clock level in the two samples around it. Configuration changes are also made in the middle of a run, while frame edges keep falling, and the measured phase lengths must stay those of the captured configuration.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef struct packed {
    logic       usb;
    logic [1:0] rate;
    logic       inv;
  } clk_cfg_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bclk_div.sv
module bclk_div #(
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] half_len,
  output logic          bclk_q,
  output logic          fall_tick
);

  logic [HW-1:0] hcnt;
  logic          at_end;

  assign at_end    = (hcnt == half_len - HW'(1));
  assign fall_tick = run & at_end & bclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt   <= '0;
      bclk_q <= 1'b0;
    end else if (at_end) begin
      hcnt   <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // R1: a half period of more than one clock never ends in the cycle right after a rise
  assert_no_short_high_R1: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && half_len > HW'(1) && $rose(bclk_q)) |-> !fall_tick);

  // R1: the counter never passes the selected half period
  assert_half_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    run |-> (hcnt < half_len));

endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] frame_len,
  input  logic [CW-1:0] high_len,
  output logic          adc_lrc,
  output logic          dac_lrc
);

  logic [CW-1:0] pos;
  logic [CW-1:0] pos_nxt;
  logic          armed;

  assign pos_nxt = (pos == frame_len - CW'(1)) ? '0 : pos + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pos     <= '0;
      armed   <= 1'b0;
      adc_lrc <= 1'b0;
      dac_lrc <= 1'b0;
    end else if (tick) begin
      if (!armed) begin
        armed   <= 1'b1;
        pos     <= '0;
        adc_lrc <= 1'b1;
        dac_lrc <= 1'b1;
      end else begin
        pos     <= pos_nxt;
        adc_lrc <= (pos_nxt < high_len);
        dac_lrc <= (pos_nxt < high_len);
      end
    end
  end

  // R5: frame clocks move only on a bit-clock falling-edge strobe
  assert_lrc_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && adc_lrc != $past(adc_lrc)) |-> $past(tick));

  // R4: position stays inside the frame
  assert_pos_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
    run |-> (pos < frame_len));

  // R7: both frame clocks agree
  assert_lrc_match_R7: assert property (@(posedge clk) disable iff (rst)
    adc_lrc == dac_lrc);

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import clkgen_pkg::*;
#(
  parameter int HALF_0 = 2,
  parameter int HALF_1 = 3,
  parameter int HALF_2 = 4,
  parameter int HALF_3 = 6,
  parameter int USBF_0 = 250,
  parameter int USBF_1 = 272,
  parameter int USBF_2 = 375,
  parameter int USBF_3 = 1500,
  parameter int BITS_PER_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usb_mode,
  input  logic [1:0] rate_sel,
  input  logic       bclk_inv,
  input  logic       standby,
  output logic       bclk,
  output logic       adc_lrc,
  output logic       dac_lrc
);

  localparam int MAX_HALF  = max_of4(HALF_0, HALF_1, HALF_2, HALF_3);
  localparam int MAX_USBF  = max_of4(USBF_0, USBF_1, USBF_2, USBF_3);
  localparam int MAX_FRAME = (MAX_USBF > BITS_PER_FRAME) ? MAX_USBF : BITS_PER_FRAME;
  localparam int HW = $clog2(MAX_HALF + 1);
  localparam int CW = $clog2(MAX_FRAME + 1);
  localparam int HALF_TBL [4] = '{HALF_0, HALF_1, HALF_2, HALF_3};
  localparam int USBF_TBL [4] = '{USBF_0, USBF_1, USBF_2, USBF_3};

  clk_cfg_t      cfg_q;
  logic          run_q;
  logic          run_d;
  logic          run_en;
  logic [HW-1:0] half_len;
  logic [CW-1:0] frame_len;
  logic [CW-1:0] high_len;
  logic          div_bclk;
  logic          div_tick;
  logic          seq_tick;
  logic          bclk_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      run_d <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= ~standby;
      run_d <= run_q;
      if (!run_q) begin
        cfg_q.usb  <= usb_mode;
        cfg_q.rate <= rate_sel;
        cfg_q.inv  <= bclk_inv;
      end
    end
  end

  assign run_en   = run_q & ~standby;
  assign half_len = HW'(HALF_TBL[cfg_q.rate]);

  generate
    if (MAX_USBF > 0) begin : g_usb_len
      assign frame_len = cfg_q.usb ? CW'(USBF_TBL[cfg_q.rate]) : CW'(BITS_PER_FRAME);
    end else begin : g_div_len
      assign frame_len = CW'(BITS_PER_FRAME);
    end
  endgenerate

  assign high_len = frame_len >> 1;
  assign seq_tick = cfg_q.usb ? (run_q & run_d) : div_tick;

  bclk_div #(.HW(HW)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run_en & ~cfg_q.usb),
    .half_len  (half_len),
    .bclk_q    (div_bclk),
    .fall_tick (div_tick)
  );

  frame_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .run       (run_en),
    .tick      (seq_tick),
    .frame_len (frame_len),
    .high_len  (high_len),
    .adc_lrc   (adc_lrc),
    .dac_lrc   (dac_lrc)
  );

  assign bclk_raw = cfg_q.usb ? ~clk : div_bclk;
  assign bclk     = run_q & (bclk_raw ^ cfg_q.inv);

  // R8: standby parks every output low on the next edge
  assert_standby_low_R8: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!adc_lrc && !dac_lrc && !bclk));

  // R10: captured configuration holds while running
  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> $stable(cfg_q));

endmodule

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF [4] = '{2, 3, 4, 6};
  localparam int USBF [4] = '{250, 272, 375, 1500};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       usb_mode = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       bclk_inv = 1'b0;
  logic       standby = 1'b0;
  logic       bclk, adc_lrc, dac_lrc;

  int  nvec = 0;
  int  nfail = 0;
  bit  done = 1'b0;
  logic la, da, ba, bb;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst(rst), .usb_mode(usb_mode), .rate_sel(rate_sel),
    .bclk_inv(bclk_inv), .standby(standby),
    .bclk(bclk), .adc_lrc(adc_lrc), .dac_lrc(dac_lrc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
    la = adc_lrc; da = dac_lrc; ba = bclk;
    #5;
    bb = bclk;
  endtask

  task automatic check_idle(input string req);
    chk(la == 1'b0 && da == 1'b0, req, {la, da}, 0);
    chk(ba == 1'b0 && bb == 1'b0, req, {ba, bb}, 0);
  endtask

  task automatic run_cfg(input bit usb, input int rate, input bit inv, input bit chg);
    int h, f, hi, lo, first, n, last_edge, last_fall, phases;
    bit seen_edge;
    logic prev_la, prev_effb, effa, effb;
    h     = HALF[rate];
    f     = usb ? USBF[rate] : 128 * h;
    hi    = usb ? f / 2 : 64 * h;
    lo    = usb ? f - f / 2 : 64 * h;
    first = usb ? 3 : 1 + 2 * h;
    n     = 2 * f + first + 5;
    standby  = 1'b1;
    usb_mode = usb;
    rate_sel = 2'(rate);
    bclk_inv = inv;
    for (int k = 0; k < 4; k++) begin
      sample();
      if (k > 0) check_idle("R8");
    end
    standby   = 1'b0;
    prev_la   = 1'b0;
    prev_effb = 1'b0;
    seen_edge = 1'b0;
    last_edge = 0;
    last_fall = -1;
    phases    = 0;
    for (int i = 1; i <= n; i++) begin
      sample();
      effa = ba ^ inv;
      effb = bb ^ inv;
      chk(da == la, "R7", da, la);
      if (i == 1) chk(ba == inv, "R6", ba, inv);
      if (usb && i >= 2) begin
        chk(ba == inv, "R3", ba, inv);
        chk(bb == !inv, "R3", bb, !inv);
      end
      if (!usb && prev_effb == 1'b1 && effa == 1'b0) begin
        if (last_fall >= 0) chk(i - last_fall == 2 * h, "R1", i - last_fall, 2 * h);
        last_fall = i;
      end
      if (la != prev_la) begin
        chk(prev_effb == 1'b1 && effa == 1'b0, "R5", {prev_effb, effa}, 2);
        if (!seen_edge) begin
          chk(la == 1'b1, "R9", la, 1);
          chk(i == first, "R9", i, first);
          seen_edge = 1'b1;
        end else begin
          phases++;
          chk(i - last_edge == (la ? lo : hi), usb ? (chg ? "R4 R10" : "R4") : (chg ? "R2 R10" : "R2"),
              i - last_edge, la ? lo : hi);
        end
        last_edge = i;
      end
      prev_la   = la;
      prev_effb = effb;
      if (chg && i == n / 3) begin
        rate_sel = 2'((rate + 1) % 4);
        usb_mode = ~usb;
        bclk_inv = ~inv;
      end
    end
    chk(phases >= 3, "R2 R4", phases, 3);
    standby = 1'b1;
    sample();
    check_idle("R8");
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      sample();
      check_idle("R8");
    end
    rst = 1'b0;
    for (int u = 0; u < 2; u++)
      for (int r = 0; r < 4; r++)
        for (int v = 0; v < 2; v++)
          run_cfg(u[0], r, v[0], 1'b0);
    run_cfg(1'b1, 2, 1'b0, 1'b1);
    run_cfg(1'b0, 1, 1'b1, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule